// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an 8-bit up-counter that advances on an instruction-rate enable pulse. The pulse first passes through a prescaler with a selectable ratio of 1, 4 or 16. Each prescaled tick moves the counter up by one. When the counter equals the period register, the next tick returns it to zero. That wrap is a period match.

Each match drives a one-cycle strobe that a PWM time base can use. The match also steps a postscaler. The postscaler counts a programmable number of matches, from 1 to 16, and then sets a sticky interrupt flag. Software sees four byte-wide registers through a single address port: the counter, the period, the control byte and the flag. Software starts and stops the timer, chooses the ratios, preloads the counter and clears the flag through these registers.

Top module: `match_timer`

## Requirements
- R1: While running, each prescaled tick raises the counter by one. A tick that finds the counter equal to the period register loads 0x00 instead.
- R2: After reset, the counter reads 0x00, the period reads 0xFF, the control byte reads 0x00, the flag reads 0 and `match_pulse` is low.
- R3: Control bits [1:0] select the prescale ratio: 00 gives 1, 01 gives 4, and 10 or 11 gives 16 enable pulses per tick.
- R4: Control bits [6:3] hold a value N. The flag sets on every (N+1)-th period match counted since the postscaler was last cleared.
- R5: Once set, the flag stays set until software writes 0 to bit 0 of the flag register. A new postscaler completion in the same cycle wins over that clear.
- R6: When control bit 2 (run) is 0, enable pulses have no effect on the counter, and the counter keeps its value.
- R7: A write to the counter register or to the control register clears the prescaler and postscaler counts. A counter write takes priority over a tick in the same cycle.
- R8: `match_pulse` is high for the cycle after each period match, and in that cycle the counter reads 0x00.
- R9: With the period at 0x00, the counter stays at 0x00 and every prescaled tick is a match.
- R10: Register addresses are 0 = counter, 1 = period, 2 = control, 3 = flag. Reads are combinational on `addr`, and unused bits read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Instruction-rate enable pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| irq_flag | output | 1 | Sticky postscaled interrupt flag |
| match_pulse | output | 1 | One-cycle period-match strobe |

## Verification
The assertions assume that the prescale select changes only through a control write, which also clears the prescale count. With that, the count never exceeds the limit for the current select. They also assume that `match_pulse` implies a zero counter, because a counter write cancels any tick in its cycle. The stimulus changes settings only while `tick_en` is low, and only through register writes. It drives enable bursts of exact lengths, so each expected count and flag value follows from integer division by the prescale ratio and by (period+1).

// File: rtl/match_timer_pkg.sv
// Shared register addresses and control layout for the period-match timer.
package match_timer_pkg;
    typedef enum logic [1:0] {
        REG_COUNT  = 2'd0,
        REG_PERIOD = 2'd1,
        REG_CTRL   = 2'd2,
        REG_FLAG   = 2'd3
    } reg_addr_e;

    // Control byte: [6:3] postscale value, [2] run, [1:0] prescale select
    typedef struct packed {
        logic [3:0] post;
        logic       run;
        logic [1:0] pre;
    } ctrl_t;
endpackage

// File: rtl/mt_prescaler.sv
// Prescaler: divides the enable pulse by 1, 4 or (2**PRE_W) according to sel.
// Assumes sel changes only together with clr.
module mt_prescaler #(
    parameter int PRE_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       clr,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam logic [PRE_W-1:0] LIM_ONE  = '0;
    localparam logic [PRE_W-1:0] LIM_FOUR = PRE_W'(3);
    localparam logic [PRE_W-1:0] LIM_MAX  = {PRE_W{1'b1}};

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] limit;

    // pick terminal count for the selected ratio
    always_comb begin
        case (sel)
            2'b00:   limit = LIM_ONE;
            2'b01:   limit = LIM_FOUR;
            default: limit = LIM_MAX;
        endcase
    end

    assign tick = en && !clr && (cnt_q == limit);

    // advance or clear the divide count
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (en)       cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end

    // R3
    pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit);
endmodule

// File: rtl/mt_postscaler.sv
// Postscaler: counts period matches and reports completion on the
// (ratio+1)-th one. Assumes ratio changes only together with clr.
module mt_postscaler #(
    parameter int POST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              match,
    input  logic [POST_W-1:0] ratio,
    output logic              done
);
    logic [POST_W-1:0] cnt_q;

    assign done = match && (cnt_q == ratio);

    // count matches, wrap on completion
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (match)    cnt_q <= done ? '0 : cnt_q + 1'b1;
    end

    // R4
    post_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= ratio);
endmodule

// File: rtl/match_timer.sv
// Period-match timer: a counter that wraps on equality with a period register,
// fed by a prescaler and driving a postscaler that sets a sticky flag.
// Assumes one register access per cycle on a shared address.
module match_timer #(
    parameter int DATA_W = 8,
    parameter int PRE_W  = 4,
    parameter int POST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_flag,
    output logic              match_pulse
);
    import match_timer_pkg::*;

    localparam int CTRL_W = $bits(ctrl_t);

    logic [DATA_W-1:0] cnt_q, per_q;
    ctrl_t             ctrl_q;
    logic              flag_q, match_q;
    logic              wr_cnt, wr_per, wr_ctrl, wr_flag;
    logic              pre_tick, match_now, post_done, scal_clr;

    assign wr_cnt   = wr_en && (addr == REG_COUNT);
    assign wr_per   = wr_en && (addr == REG_PERIOD);
    assign wr_ctrl  = wr_en && (addr == REG_CTRL);
    assign wr_flag  = wr_en && (addr == REG_FLAG);
    assign scal_clr = wr_cnt || wr_ctrl;

    mt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(tick_en && ctrl_q.run),
        .clr(scal_clr), .sel(ctrl_q.pre), .tick(pre_tick)
    );

    assign match_now = pre_tick && (cnt_q == per_q);

    mt_postscaler #(.POST_W(POST_W)) u_post (
        .clk(clk), .rst_n(rst_n), .clr(scal_clr), .match(match_now),
        .ratio(ctrl_q.post), .done(post_done)
    );

    // counter: software load wins, else count and wrap on period match
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (wr_cnt)   cnt_q <= wr_data;
        else if (pre_tick) cnt_q <= match_now ? '0 : cnt_q + 1'b1;
    end

    // period and control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q  <= '1;
            ctrl_q <= '0;
        end else begin
            if (wr_per)  per_q  <= wr_data;
            if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    // sticky flag: hardware set beats software write
    always_ff @(posedge clk) begin
        if (!rst_n)         flag_q <= 1'b0;
        else if (post_done) flag_q <= 1'b1;
        else if (wr_flag)   flag_q <= wr_data[0];
    end

    // registered match strobe
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= match_now;
    end

    // read mux
    always_comb begin
        case (reg_addr_e'(addr))
            REG_COUNT:  rd_data = cnt_q;
            REG_PERIOD: rd_data = per_q;
            REG_CTRL:   rd_data = DATA_W'(ctrl_q);
            default:    rd_data = DATA_W'(flag_q);
        endcase
    end

    assign irq_flag    = flag_q;
    assign match_pulse = match_q;

    // R8
    match_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_q |-> (cnt_q == '0));
    // R6
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.run && !wr_cnt) |=> (cnt_q == $past(cnt_q)));
    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr_flag && !wr_data[0])) |=> flag_q);
    // R9
    zero_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (per_q == '0 && cnt_q == '0 && !wr_en) |=> (cnt_q == '0));
endmodule

// File: tb/match_timer_test.sv
module match_timer_test;
    logic       clk = 0, rst_n = 0, tick_en = 0, wr_en = 0;
    logic [1:0] addr = 0;
    logic [7:0] wr_data = 0, rd_data;
    logic       irq_flag, match_pulse;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    match_timer uut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .irq_flag(irq_flag), .match_pulse(match_pulse));

    // {period, presel, post, ticks, exp_count, exp_flag}
    typedef struct packed {
        logic [7:0] per; logic [1:0] pre; logic [3:0] post;
        logic [7:0] n; logic [7:0] cnt; logic flag;
    } vec_t;
    localparam vec_t VECS [10] = '{
        '{8'd9,   2'd0, 4'd0,  8'd5,   8'd5,   1'b0},  // R1
        '{8'd9,   2'd0, 4'd0,  8'd10,  8'd0,   1'b1},  // R1 R4
        '{8'd9,   2'd1, 4'd0,  8'd23,  8'd5,   1'b0},  // R3 /4
        '{8'd4,   2'd2, 4'd0,  8'd80,  8'd0,   1'b1},  // R3 /16
        '{8'd3,   2'd0, 4'd2,  8'd11,  8'd3,   1'b0},  // R4 /3
        '{8'd3,   2'd0, 4'd2,  8'd12,  8'd0,   1'b1},  // R4
        '{8'd0,   2'd0, 4'd15, 8'd15,  8'd0,   1'b0},  // R9
        '{8'd0,   2'd0, 4'd15, 8'd16,  8'd0,   1'b1},  // R9 /16
        '{8'd255, 2'd0, 4'd0,  8'd200, 8'd200, 1'b0},  // R1
        '{8'd9,   2'd3, 4'd0,  8'd33,  8'd2,   1'b0}   // R3 sel 11
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; #1 d = rd_data;
    endtask

    task automatic run(input int n);
        @(negedge clk); tick_en = 1;
        repeat (n) @(negedge clk);
        tick_en = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R2 reset values; R10 addresses
        rd(0, v); chk("R2 count", v, 8'h00);
        rd(1, v); chk("R2 period", v, 8'hFF);
        rd(2, v); chk("R2 ctrl", v, 8'h00);
        rd(3, v); chk("R2 flag", v, 8'h00);
        chk("R2 match", {7'd0, match_pulse}, 8'd0);

        for (int i = 0; i < 10; i++) begin
            wr(2, 8'h00);
            wr(1, VECS[i].per);
            wr(0, 8'h00);
            wr(3, 8'h00);
            wr(2, {1'b0, VECS[i].post, 1'b1, VECS[i].pre});
            run(int'(VECS[i].n));
            rd(0, v); chk("R1 R3 vector count", v, VECS[i].cnt);
            chk("R4 vector flag", {7'd0, irq_flag}, {7'd0, VECS[i].flag});
        end

        // R10 control readback: post 5, run, pre 01
        wr(2, {1'b0, 4'd5, 1'b1, 2'b01});
        rd(2, v); chk("R10 ctrl readback", v, 8'h2D);

        // R7 counter write clears prescaler
        wr(2, 8'h00); wr(1, 8'hFF); wr(2, {1'b0, 4'd0, 1'b1, 2'b01});
        run(3);
        wr(0, 8'd7);
        run(3);
        rd(0, v); chk("R7 prescale cleared", v, 8'd7);
        run(1);
        rd(0, v); chk("R7 tick after clear", v, 8'd8);

        // R6 run bit off holds the counter
        wr(2, 8'h00);
        run(20);
        rd(0, v); chk("R6 halted", v, 8'd8);

        // R8 match strobe
        wr(1, 8'd2); wr(0, 8'd2); wr(3, 8'h00); wr(2, 8'h04);
        @(negedge clk); tick_en = 1;
        @(negedge clk); tick_en = 0;
        chk("R8 strobe high", {7'd0, match_pulse}, 8'd1);
        addr = 0; #1 chk("R8 count zero", rd_data, 8'd0);
        @(negedge clk);
        chk("R8 strobe one cycle", {7'd0, match_pulse}, 8'd0);

        // R5 flag sticky, cleared only by writing 0
        wr(2, 8'h00);
        rd(3, v); chk("R5 flag set", v, 8'd1);
        run(10);
        wr(3, 8'h01);
        rd(3, v); chk("R5 flag stays", v, 8'd1);
        wr(3, 8'h00);
        rd(3, v); chk("R5 flag cleared", v, 8'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule